// File: doc/BRIEF.md
# Sleep and Event Wait Controller

This block decides when a processor core stops issuing instructions and when it resumes. The core issues three kinds of single-cycle request: wait for an interrupt, wait for an event, and signal an event to other cores. A one-bit sticky event flag remembers that an event has already occurred. A later wait-for-event can then finish at once, without the core going to sleep.

While the core sleeps, the controller watches three inputs: the interrupt-pending level, the external event input and the debug-entry request. When the condition that belongs to the current kind of wait is met, it ends the sleep and raises a one-cycle wake pulse. Signalling an event sets the local flag and sends a one-cycle pulse to peer cores. The flag is visible on an output.

Top module: `sleep_event_ctrl`

## Requirements
- R1: After reset, `sleeping`, `wake`, `evt_out` and `evt_flag` are all 0.
- R2: A `wfi_req` taken while awake, with `irq_pend` and `dbg_req` both low, raises `sleeping` in the next cycle. The core stays asleep until `irq_pend` or `dbg_req` is sampled high. `ext_evt` does not end this sleep.
- R3: When a wake condition is sampled at a clock edge, `sleeping` is 0 after that edge and `wake` is 1 for exactly that one cycle.
- R4: A `wfe_req` taken while awake with `evt_flag` set does not sleep, and `evt_flag` is 0 in the next cycle.
- R5: A `wfe_req` taken while awake, with `evt_flag`, `sev_req`, `ext_evt`, `irq_pend` and `dbg_req` all low, raises `sleeping`. The sleep ends when `ext_evt`, `irq_pend` or `dbg_req` is sampled high, and `evt_flag` is 0 afterwards.
- R6: A `sev_req` taken while awake sets `evt_flag` in the next cycle and drives `evt_out` high for that one cycle only.
- R7: A `sev_req` or an `ext_evt` in the same cycle as `wfe_req` lets the wait complete at once. The core does not sleep and `evt_flag` is 0 in the next cycle. A `sev_req` still produces its `evt_out` pulse.
- R8: `ext_evt` sets `evt_flag` while the core is awake or asleep on a wait-for-interrupt. A wake from a wait-for-interrupt leaves `evt_flag` unchanged.
- R9: A `wfi_req` taken while `irq_pend` or `dbg_req` is high does not sleep and gives no `wake` pulse.
- R10: `wfi_req`, `wfe_req` and `sev_req` have no effect while `sleeping` is 1. No `evt_out` pulse appears and `evt_flag` does not change.
- R11: If `wfi_req` and `wfe_req` are both high, the wait-for-interrupt is taken and the wait-for-event is ignored, leaving `evt_flag` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| sev_req | input | 1 | Send-event request pulse |
| irq_pend | input | 1 | Interrupt pending level |
| ext_evt | input | 1 | Event pulse from outside the core |
| dbg_req | input | 1 | Debug-entry request |
| sleeping | output | 1 | Core halted; instruction issue stops |
| wake | output | 1 | One-cycle pulse as sleeping falls |
| evt_out | output | 1 | One-cycle event pulse to peer cores |
| evt_flag | output | 1 | Local sticky event flag |

## Verification
The single-cycle check on `evt_out` assumes that `sev_req` is never high in two consecutive cycles. The assertions also assume that `wfi_req`, `wfe_req` and `sev_req` arrive only as one-cycle pulses from an awake core. The stimulus drives every request for exactly one cycle with idle cycles between requests, and it holds `irq_pend` for one cycle only when that level is used as a wake source. Requests issued during sleep occur only in the checks for R10, which assert them for one cycle.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAIT_INT = 2'd1,
    ST_WAIT_EVT = 2'd2
  } slp_state_t;

  // wake condition for each sleeping state
  function automatic logic wake_due(slp_state_t s, logic irq, logic dbg, logic ext);
    case (s)
      ST_WAIT_INT: wake_due = irq | dbg;
      ST_WAIT_EVT: wake_due = irq | dbg | ext;
      default:     wake_due = 1'b0;
    endcase
  endfunction

  // an event is available to a wait-for-event in this cycle
  function automatic logic event_ready(logic flag, logic sev, logic ext);
    event_ready = flag | sev | ext;
  endfunction

endpackage

// File: rtl/slp_req_decode.sv
module slp_req_decode
  import sleep_ctl_pkg::*;
(
  input  logic run,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic sev_req,
  input  logic irq_pend,
  input  logic dbg_req,
  input  logic ext_evt,
  input  logic flag,
  output logic sev_ok,
  output logic go_int,
  output logic go_evt,
  output logic wfe_skip
);
  logic wfi_take;
  logic wfe_take;
  logic ready;
  logic break_in;

  always_comb begin
    ready    = event_ready(flag, sev_req, ext_evt);
    break_in = irq_pend | dbg_req;
    sev_ok   = run & sev_req;
    wfi_take = run & wfi_req;
    wfe_take = run & wfe_req & ~wfi_req;
    go_int   = wfi_take & ~break_in;
    wfe_skip = wfe_take & ready;
    go_evt   = wfe_take & ~ready & ~break_in;
  end
endmodule

// File: rtl/slp_state_fsm.sv
module slp_state_fsm
  import sleep_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_int,
  input  logic       go_evt,
  input  logic       irq_pend,
  input  logic       dbg_req,
  input  logic       ext_evt,
  output slp_state_t state,
  output logic       wake_hit,
  output logic       wake
);
  slp_state_t state_n;

  always_comb begin
    wake_hit = wake_due(state, irq_pend, dbg_req, ext_evt);
    state_n  = state;
    case (state)
      ST_RUN: begin
        if (go_int)      state_n = ST_WAIT_INT;
        else if (go_evt) state_n = ST_WAIT_EVT;
      end
      ST_WAIT_INT, ST_WAIT_EVT: if (wake_hit) state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      wake  <= 1'b0;
    end else begin
      state <= state_n;
      wake  <= wake_hit;
    end
  end
endmodule

// File: rtl/slp_event_latch.sv
module slp_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sev_ok,
  input  logic ext_evt,
  input  logic in_evt_wait,
  input  logic wfe_skip,
  output logic flag,
  output logic evt_out
);
  logic set_now;

  always_comb set_now = sev_ok | (ext_evt & ~in_evt_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      evt_out <= 1'b0;
    end else begin
      // consumed by a completing wait, or held clear while waiting on an event
      if (wfe_skip || in_evt_wait) flag <= 1'b0;
      else                         flag <= flag | set_now;
      evt_out <= sev_ok;
    end
  end
endmodule

// File: rtl/sleep_event_ctrl.sv
module sleep_event_ctrl
  import sleep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic sev_req,
  input  logic irq_pend,
  input  logic ext_evt,
  input  logic dbg_req,
  output logic sleeping,
  output logic wake,
  output logic evt_out,
  output logic evt_flag
);
  slp_state_t state;
  logic run;
  logic in_evt_wait;
  logic sev_ok;
  logic go_int;
  logic go_evt;
  logic wfe_skip;
  logic wake_hit;

  assign run         = (state == ST_RUN);
  assign in_evt_wait = (state == ST_WAIT_EVT);
  assign sleeping    = ~run;

  slp_req_decode dec_i (
    .run(run), .wfi_req(wfi_req), .wfe_req(wfe_req), .sev_req(sev_req),
    .irq_pend(irq_pend), .dbg_req(dbg_req), .ext_evt(ext_evt), .flag(evt_flag),
    .sev_ok(sev_ok), .go_int(go_int), .go_evt(go_evt), .wfe_skip(wfe_skip)
  );

  slp_state_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .go_int(go_int), .go_evt(go_evt),
    .irq_pend(irq_pend), .dbg_req(dbg_req), .ext_evt(ext_evt),
    .state(state), .wake_hit(wake_hit), .wake(wake)
  );

  slp_event_latch evl_i (
    .clk(clk), .rst_n(rst_n), .sev_ok(sev_ok), .ext_evt(ext_evt),
    .in_evt_wait(in_evt_wait), .wfe_skip(wfe_skip),
    .flag(evt_flag), .evt_out(evt_out)
  );
endmodule

// File: rtl/sleep_event_ctrl_chk.sv
module sleep_event_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wfi_req,
  input logic wfe_req,
  input logic sev_req,
  input logic irq_pend,
  input logic ext_evt,
  input logic dbg_req,
  input logic sleeping,
  input logic wake,
  input logic evt_out,
  input logic evt_flag,
  input logic wfe_skip,
  input logic wake_hit
);
  // R3: wake only in the first awake cycle after a sleep
  p_wake_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (!sleeping && $past(sleeping)));

  // R3: a sampled wake condition ends the sleep
  p_wake_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && wake_hit) |=> (!sleeping && wake));

  // R2: with no wake source at all, sleep continues
  p_hold_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !irq_pend && !dbg_req && !ext_evt) |=> sleeping);

  // R4: wait-for-event with the flag set completes without sleeping
  p_wfe_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfe_req && !wfi_req && evt_flag) |=> (!sleeping && !evt_flag));

  // R6: an event pulse always stems from a send-event taken while awake
  p_evout_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> $past(sev_req && !sleeping));

  // R6: single-cycle pulse (stimulus never repeats sev_req back to back)
  p_evout_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |=> !evt_out);

  // R7: the completing wait consumes the event
  p_skip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wfe_skip |=> !evt_flag);

  // R10: requests during sleep leave the flag untouched when no event arrives
  p_sleep_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !ext_evt && !wake_hit) |=> $stable(evt_flag));
endmodule

bind sleep_event_ctrl sleep_event_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
  .sev_req(sev_req), .irq_pend(irq_pend), .ext_evt(ext_evt), .dbg_req(dbg_req),
  .sleeping(sleeping), .wake(wake), .evt_out(evt_out), .evt_flag(evt_flag),
  .wfe_skip(wfe_skip), .wake_hit(wake_hit)
);

// File: tb/sleep_event_ctrl_tb.sv
module sleep_event_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, sev_req = 0, irq_pend = 0, ext_evt = 0, dbg_req = 0;
  logic sleeping, wake, evt_out, evt_flag;
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic exp_flag;

  always #4 clk = ~clk;   // 125 MHz

  sleep_event_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_req(sev_req), .irq_pend(irq_pend), .ext_evt(ext_evt), .dbg_req(dbg_req),
    .sleeping(sleeping), .wake(wake), .evt_out(evt_out), .evt_flag(evt_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    wfi_req = 0; wfe_req = 0; sev_req = 0; irq_pend = 0; ext_evt = 0; dbg_req = 0;
  endtask

  // drive the current inputs for one edge, then clear them; we sit at a negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  // source code: 0 = ext_evt, 1 = irq_pend, 2 = dbg_req
  task automatic drive_src(int src);
    if (src == 0) ext_evt = 1;
    else if (src == 1) irq_pend = 1;
    else dbg_req = 1;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 sleeping", sleeping, 0);
    chk("R1 wake", wake, 0);
    chk("R1 evt_out", evt_out, 0);
    chk("R1 evt_flag", evt_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // R6: send-event
    sev_req = 1; step();
    chk("R6 evt_out pulse", evt_out, 1);
    chk("R6 flag set", evt_flag, 1);
    step();
    chk("R6 evt_out one cycle", evt_out, 0);

    // R4: wfe with flag set completes at once
    wfe_req = 1; step();
    chk("R4 no sleep", sleeping, 0);
    chk("R4 flag cleared", evt_flag, 0);
    chk("R4 no wake", wake, 0);

    // R5/R3 sweep over wake sources for a wait-for-event
    for (int src = 0; src < 3; src++) begin
      wfe_req = 1; step();
      chk("R5 sleeps", sleeping, 1);
      repeat (3) step();
      chk("R5 still asleep", sleeping, 1);
      drive_src(src); step();
      chk("R3 awake after source", sleeping, 0);
      chk("R3 wake pulse", wake, 1);
      chk("R5 flag clear", evt_flag, 0);
      step();
      chk("R3 wake one cycle", wake, 0);
    end

    // R10: requests during sleep are ignored
    wfe_req = 1; step();
    sev_req = 1; step();
    chk("R10 no evt_out", evt_out, 0);
    chk("R10 flag unchanged", evt_flag, 0);
    chk("R10 still asleep", sleeping, 1);
    wfi_req = 1; step();
    chk("R10 wfi ignored", sleeping, 1);
    irq_pend = 1; step();
    chk("R10 woke", sleeping, 0);
    step();

    // R2/R8 sweep over wake sources for a wait-for-interrupt
    for (int src = 1; src < 3; src++) begin
      wfi_req = 1; step();
      chk("R2 sleeps", sleeping, 1);
      ext_evt = 1; step();
      chk("R2 ext_evt does not wake", sleeping, 1);
      chk("R8 ext_evt sets flag in wfi sleep", evt_flag, 1);
      drive_src(src); step();
      chk("R3 wfi wake", wake, 1);
      chk("R3 wfi awake", sleeping, 0);
      chk("R8 flag kept by wfi wake", evt_flag, 1);
      wfe_req = 1; step();
      chk("R4 consume flag", evt_flag, 0);
    end

    // R9: wfi with an interrupt or debug already pending
    for (int src = 1; src < 3; src++) begin
      wfi_req = 1; drive_src(src); step();
      chk("R9 no sleep", sleeping, 0);
      chk("R9 no wake", wake, 0);
    end

    // R7: sev together with wfe
    sev_req = 1; wfe_req = 1; step();
    chk("R7 sev+wfe no sleep", sleeping, 0);
    chk("R7 sev+wfe flag clear", evt_flag, 0);
    chk("R7 sev+wfe evt_out", evt_out, 1);
    step();
    ext_evt = 1; wfe_req = 1; step();
    chk("R7 ext+wfe no sleep", sleeping, 0);
    chk("R7 ext+wfe flag clear", evt_flag, 0);

    // R8: ext_evt while awake
    ext_evt = 1; step();
    chk("R8 ext sets flag awake", evt_flag, 1);

    // R11: wfi and wfe together with flag set
    exp_flag = 1;
    wfi_req = 1; wfe_req = 1; step();
    chk("R11 wfi taken", sleeping, 1);
    chk("R11 flag untouched", evt_flag, exp_flag);
    irq_pend = 1; step();
    chk("R11 woke", sleeping, 0);
    chk("R11 flag after wake", evt_flag, exp_flag);
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule